// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block holds the byte-wide control registers that sit behind a serial control port. Each register has two copies. The pending copy takes every write from the serial engine. The active copy drives the core logic. The active copy changes only when the `io_update` input pulses. On that cycle every pending value moves into its active register at once, so a group of related settings written one by one all take effect together.

Serial reads return the active copy by default. One register bit switches readback to the pending copy, so software can check what the next update will apply. The active copy of every register is exposed as a flat output vector. The bit-order control that the serial engine uses is also brought out on its own pin, and it follows the active copy like every other field.

The write channel is a valid/ready stream that never applies back-pressure. The read channel is a request stream followed by a response stream. A new request is accepted only while the response slot is empty or is being drained in the same cycle. A response that is not taken is held unchanged until `rd_rsp_ready` is seen high.

Top module: `regbank_top`

## Requirements
- R1: After reset, the pending and active copies of every mapped register (addresses 0x00 to 0x34) hold the same default. Address 0x00 and address 0x04 default to 0x00. Every other address `a` defaults to `(a*37 + 17) mod 256`.
- R2: A write accepted on a mapped address changes only the pending copy of that register. No active output changes until an update.
- R3: A cycle with `io_update` high copies every pending value into its active register. The new values appear on `act_regs` (register `i` in bits `[8*i+7:8*i]`) in the next cycle.
- R4: When a write and `io_update` are in the same cycle, the active register receives the pending value from before the write. The written value stays pending.
- R5: While bit 0 of the pending copy of register 0x04 is 0, a read returns the active copy.
- R6: While bit 0 of the pending copy of register 0x04 is 1, a read returns the pending copy. This selection takes effect for requests accepted after the write to 0x04, with no update needed.
- R7: `lsb_first` equals bit 6 of the active copy of register 0x00. It changes only through an update.
- R8: Writes to addresses above 0x34 change no register. Reads of addresses above 0x34 return 0x00.
- R9: A read request is accepted when `rd_req_valid` and `rd_req_ready` are both high, and `rd_req_ready` is high only while no response is pending or the pending response is being taken. The response is valid in the cycle after acceptance, and its data is held while `rd_rsp_ready` is low.
- R10: `wr_ready` is always high, so every write with `wr_valid` high is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready (always high) |
| wr_addr | input | 13 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request ready |
| rd_req_addr | input | 13 | Read byte address |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_ready | input | 1 | Read response taken |
| rd_rsp_data | output | 8 | Read response byte |
| io_update | input | 1 | Copy all pending values to active |
| act_regs | output | 424 | Active copies, register i in bits [8i+7:8i] |
| lsb_first | output | 1 | Active bit-order control |

## Verification
The assertions check the following on every cycle:
- the active vector and `lsb_first` stay still in any cycle without an update;
- after an update pulse, the active vector matches the pending copies as they were on that edge;
- every accepted read yields a response, and a stalled response keeps its data;
- a read of an address above 0x34 returns 0x00.

Only the bench scenarios can show the rest:
- which copy a read returns, and the point at which the readback bit starts to steer it;
- the correct default for each address;
- that writes to unmapped addresses leave all stored values unchanged;
- the ordering when a write and an update fall in the same cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int ADDR_W    = 13;
  localparam int DATA_W    = 8;
  localparam int LAST_ADDR = 52;
  localparam int ORDER_REG = 0;
  localparam int ORDER_BIT = 6;
  localparam int RDSEL_REG = 4;
  localparam int RDSEL_BIT = 0;

  // Reset value for the register at byte address idx.
  function automatic logic [7:0] reg_default(int unsigned idx);
    logic [31:0] v;
    if (idx == ORDER_REG || idx == RDSEL_REG) return 8'h00;
    v = idx * 32'd37 + 32'd17;
    return v[7:0];
  endfunction
endpackage

// File: rtl/regbank_wdec.sv
module regbank_wdec #(
  parameter int ADDR_W   = 13,
  parameter int NUM_REGS = 53
) (
  input  logic                wr_fire,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_REGS-1:0] wr_sel
);
  // Unmapped addresses match no entry, so they write nothing.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign wr_sel[i] = wr_fire && (wr_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int                 DATA_W    = 8,
  parameter logic [DATA_W-1:0]  RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= RESET_VAL;
      act_q  <= RESET_VAL;
    end else begin
      if (wr_en) pend_q <= wr_data;
      // Non-blocking: the active copy takes the pre-write pending value.
      if (upd)   act_q  <= pend_q;
    end
  end
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 53
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REGS*DATA_W-1:0]   pend_flat,
  input  logic [NUM_REGS*DATA_W-1:0]   act_flat,
  input  logic                         use_pend,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [DATA_W-1:0]            rsp_data
);
  logic [DATA_W-1:0] pick;
  logic              req_fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (req_addr == ADDR_W'(i))
        pick = use_pend ? pend_flat[i*DATA_W +: DATA_W]
                        : act_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= pick;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int LAST = LAST_ADDR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    rd_req_valid,
  output logic                    rd_req_ready,
  input  logic [AW-1:0]           rd_req_addr,
  output logic                    rd_rsp_valid,
  input  logic                    rd_rsp_ready,
  output logic [DW-1:0]           rd_rsp_data,
  input  logic                    io_update,
  output logic [(LAST+1)*DW-1:0]  act_regs,
  output logic                    lsb_first
);
  localparam int NREGS = LAST + 1;

  logic [NREGS-1:0]    wr_sel;
  logic [NREGS*DW-1:0] pend_flat;
  logic                use_pend;

  assign wr_ready = 1'b1;

  regbank_wdec #(.ADDR_W(AW), .NUM_REGS(NREGS)) u_wdec (
    .wr_fire (wr_valid && wr_ready),
    .wr_addr (wr_addr),
    .wr_sel  (wr_sel)
  );

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    regbank_cell #(
      .DATA_W    (DW),
      .RESET_VAL (DW'(reg_default(i)))
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_sel[i]),
      .wr_data (wr_data),
      .upd     (io_update),
      .pend_q  (pend_flat[i*DW +: DW]),
      .act_q   (act_regs[i*DW +: DW])
    );
  end

  // The readback select follows the pending copy, so it acts without an update.
  assign use_pend  = pend_flat[RDSEL_REG*DW + RDSEL_BIT];
  assign lsb_first = act_regs[ORDER_REG*DW + ORDER_BIT];

  regbank_rdport #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NREGS)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_flat (pend_flat),
    .act_flat  (act_regs),
    .use_pend  (use_pend),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_req_addr),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (rd_rsp_ready),
    .rsp_data  (rd_rsp_data)
  );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int LAST = 52
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    io_update,
  input logic [(LAST+1)*DW-1:0]  act_regs,
  input logic [(LAST+1)*DW-1:0]  pend_flat,
  input logic                    lsb_first,
  input logic                    rd_req_valid,
  input logic                    rd_req_ready,
  input logic [AW-1:0]           rd_req_addr,
  input logic                    rd_rsp_valid,
  input logic                    rd_rsp_ready,
  input logic [DW-1:0]           rd_rsp_data
);
  // R2
  act_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_update |=> $stable(act_regs));

  // R3
  upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_update |=> act_regs == $past(pend_flat));

  // R7
  order_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_update |=> $stable(lsb_first));

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> rd_rsp_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |=> (rd_rsp_valid && $stable(rd_rsp_data)));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready && rd_req_addr > AW'(LAST)) |=> rd_rsp_data == '0);
endmodule

bind regbank_top regbank_chk #(.AW(AW), .DW(DW), .LAST(LAST)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_update    (io_update),
  .act_regs     (act_regs),
  .pend_flat    (pend_flat),
  .lsb_first    (lsb_first),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_ready (rd_rsp_ready),
  .rd_rsp_data  (rd_rsp_data)
);

// File: tb/regbank_top_test.sv
module regbank_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 53;
  localparam int AW = 13;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_req_valid = 1'b0, rd_req_ready;
  logic [AW-1:0] rd_req_addr = '0;
  logic rd_rsp_valid, rd_rsp_ready = 1'b1;
  logic [DW-1:0] rd_rsp_data;
  logic io_update = 1'b0;
  logic [NREG*DW-1:0] act_regs;
  logic lsb_first;

  regbank_top uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .io_update(io_update), .act_regs(act_regs), .lsb_first(lsb_first)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mpend [NREG];
  logic [7:0] mact  [NREG];

  function automatic logic [7:0] dflt(int a);
    if (a == 0 || a == 4) return 8'h00;
    return 8'((a * 37 + 17) % 256);
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops expected read data as responses are taken.
  always @(negedge clk) begin : mon
    logic [7:0] e;
    string r;
    if (rst_n && rd_rsp_valid && rd_rsp_ready) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected response", rd_rsp_data, 0);
      else begin
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        chk(rd_rsp_data == e, r, rd_rsp_data, e);
      end
    end
  end

  task automatic wr(int a, logic [7:0] d);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d;
    chk(wr_ready == 1'b1, "R10 wr_ready", wr_ready, 1);
    @(negedge clk);
    wr_valid = 0;
    if (a < NREG) mpend[a] = d;
  endtask

  task automatic upd();
    io_update = 1;
    @(negedge clk);
    io_update = 0;
    for (int i = 0; i < NREG; i++) mact[i] = mpend[i];
  endtask

  task automatic wr_upd(int a, logic [7:0] d);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d; io_update = 1;
    @(negedge clk);
    wr_valid = 0; io_update = 0;
    for (int i = 0; i < NREG; i++) mact[i] = mpend[i];
    if (a < NREG) mpend[a] = d;
  endtask

  task automatic rd(int a, string r);
    logic [7:0] e;
    while (!rd_req_ready) @(negedge clk);
    if (a >= NREG) e = 8'h00;
    else e = mpend[4][0] ? mpend[a] : mact[a];
    exp_q.push_back(e);
    tag_q.push_back(r);
    rd_req_valid = 1; rd_req_addr = AW'(a);
    @(negedge clk);
    rd_req_valid = 0;
  endtask

  task automatic chk_act(string r);
    for (int i = 0; i < NREG; i++)
      chk(act_regs[i*DW +: DW] == mact[i], r, act_regs[i*DW +: DW], mact[i]);
    chk(lsb_first == mact[0][6], {r, " lsb_first"}, lsb_first, mact[0][6]);
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      mpend[i] = dflt(i);
      mact[i]  = dflt(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: defaults on both copies
    chk(rd_rsp_valid == 1'b0, "R1 no response after reset", rd_rsp_valid, 0);
    chk_act("R1 active default");
    for (int i = 0; i < NREG; i++) rd(i, "R1 R5 active default read");
    wr(4, 8'h01);
    for (int i = 0; i < NREG; i++) rd(i, "R1 R6 pending default read");
    wr(4, 8'h00);
    drain();

    // R2 / R5: a write stays pending and active reads keep the old value
    wr(16, 8'hA5);
    wr(40, 8'h5A);
    chk_act("R2 active unchanged after write");
    rd(16, "R5 read active after write");
    rd(40, "R5 read active after write");

    // R6: the readback select acts at once
    wr(4, 8'h01);
    rd(16, "R6 read pending");
    rd(40, "R6 read pending");
    rd(4, "R6 read pending select reg");
    drain();

    // R7: bit order follows only the active copy
    wr(0, 8'h40);
    chk(lsb_first == 1'b0, "R7 lsb_first before update", lsb_first, 0);
    upd();
    chk(lsb_first == 1'b1, "R7 lsb_first after update", lsb_first, 1);
    chk_act("R3 all active after update");

    // R4: a write and an update in the same cycle
    wr_upd(32, 8'h3C);
    chk(act_regs[32*DW +: DW] == dflt(32), "R4 active keeps old pending",
        act_regs[32*DW +: DW], dflt(32));
    rd(32, "R4 new value still pending");
    wr(4, 8'h00);
    rd(32, "R4 active read old value");
    upd();
    chk(act_regs[32*DW +: DW] == 8'h3C, "R4 value lands on next update",
        act_regs[32*DW +: DW], 8'h3C);
    drain();

    // R8: unmapped addresses
    wr(53, 8'hFF);
    wr(8191, 8'h77);
    wr(100, 8'h12);
    rd(53, "R8 unmapped read");
    rd(8191, "R8 unmapped read");
    upd();
    chk_act("R8 no register changed");
    wr(4, 8'h01);
    for (int i = 0; i < NREG; i++) rd(i, "R8 pending untouched");
    wr(4, 8'h00);
    drain();

    // R9: response stall and back-pressure on requests
    @(posedge clk); #1 rd_rsp_ready = 0;
    @(negedge clk);
    rd(16, "R9 stalled read data");
    repeat (3) begin
      @(negedge clk);
      chk(rd_rsp_valid == 1'b1, "R9 response held", rd_rsp_valid, 1);
      chk(rd_req_ready == 1'b0, "R9 request stalled", rd_req_ready, 0);
    end
    @(posedge clk); #1 rd_rsp_ready = 1;
    @(negedge clk);
    rd(40, "R9 read after stall");
    rd(0, "R9 back to back");
    drain();

    finish_run();
  end
endmodule